// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on a single line. A frame is a low start bit, eight or nine data bits sent least significant bit first, and a high stop bit. A one-word holding register sits in front of the shift register. Software can therefore queue the next word while the current frame is still being sent, and back-to-back frames leave no idle gap between them.

The bit timer is built in. It is set by an 8-bit divisor N and a speed select. One bit lasts 16·(N+1) clock cycles at high speed and 64·(N+1) cycles at low speed. The timer runs only while a frame is in flight. It restarts at every frame that begins from idle, and whenever the divisor or the speed select changes.

Two flags report progress. One shows that the holding register can take a word. The other shows that the shift register has nothing left to send.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever nothing is queued or in flight, `serial_o` is 1 and both `hold_empty_o` and `shift_empty_o` are 1.
- R2: A frame is one low start bit, then the data bits least significant bit first, then one high stop bit. There are 8 data bits when `mode9_i` is 0 and 9 when it is 1; the ninth bit goes last.
- R3: A word written while `shift_empty_o` is 1 and the holding register is empty goes straight into the shift register. The start bit is on the line in the next cycle, `hold_empty_o` stays 1, and `shift_empty_o` becomes 0.
- R4: A write into the holding register clears `hold_empty_o` one cycle late: the flag still reads 1 in the cycle after the write edge and reads 0 in the cycle after that.
- R5: A held word moves into the shift register at the edge that ends the last data bit. `hold_empty_o` rises one cycle after that edge, and the held frame's start bit follows the stop bit with no idle cycle.
- R6: `shift_empty_o` rises at the start of the stop bit of the last queued word. It stays 0 during a stop bit while another word is already staged behind it.
- R7: Each bit lasts 16·(N+1) cycles when `hs_i` is 1 and 64·(N+1) cycles when `hs_i` is 0, where N is `div_i`.
- R8: The ninth data bit is sampled from `bit9_i` at the moment the word enters the shift register, not at the moment it is written.
- R9: In 9-bit mode, a ninth bit of 1 keeps the line high for two bit periods after the eight data bits.
- R10: A write while the holding register is full replaces the held word, and the replaced word is never sent.
- R11: With `tx_en_i` at 0, the frame in flight is dropped and the held word is discarded. One cycle later `serial_o`, `hold_empty_o` and `shift_empty_o` are all 1, and writes are ignored.
- R12: A change of `div_i` or `hs_i` restarts the bit timer. The bit in progress ends one full new period after the edge that sees the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; sets the oscillator rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable; 0 aborts and clears |
| wr_i | input | 1 | Write strobe for one word |
| wr_data_i | input | 8 | Low eight data bits of the word |
| bit9_i | input | 1 | Ninth data bit, sampled at transfer |
| mode9_i | input | 1 | 1 selects 9 data bits per frame |
| div_i | input | 8 | Bit-rate divisor N |
| hs_i | input | 1 | 1 selects 16 cycles per unit, 0 selects 64 |
| serial_o | output | 1 | Serial line, idles high |
| hold_empty_o | output | 1 | Holding register can accept a word |
| shift_empty_o | output | 1 | Shift register has nothing left to send |

## Verification
A write sampled at edge k puts the start bit on the line in the cycle after k when it passes straight through. The holding flag falls after edge k+1. With period P and n data bits, the held word moves in at edge k+(1+n)·P, so the holding flag rises after the next edge and the second start bit begins at k+(2+n)·P. The bench counts clock edges from each write and samples in the cycles just before and just after each of these edges. Serial data is sampled in the middle of each bit. The abort and the divisor change are checked in the first and the full-period cycle after the edge that sees them.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned HS_SH = 4,
  parameter int unsigned LS_SH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hs_i,
  output logic             tick_o
);
  localparam int unsigned MAX_SH = (HS_SH > LS_SH) ? HS_SH : LS_SH;
  localparam int unsigned CNT_W  = DIV_W + MAX_SH;

  logic [CNT_W-1:0] cnt_q, lim;
  logic [CNT_W:0]   per;
  logic [DIV_W:0]   cfg_q;
  logic             reload;

  assign reload = ({hs_i, div_i} != cfg_q);

  always_comb begin
    per = (CNT_W+1)'(div_i) + 1'b1;
    per = hs_i ? (per << HS_SH) : (per << LS_SH);
    lim = CNT_W'(per - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      cfg_q <= {hs_i, div_i};
      if (!run_i || reload || cnt_q == lim) cnt_q <= '0;
      else                                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && !reload && (cnt_q == lim);

  // shortest period is 2**HS_SH cycles, so ticks never touch
  p_tick_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic          direct_i,
  input  logic          take_i,
  input  logic [DW-1:0] data_i,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          empty_o
);
  logic          full_q, empty_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      data_q  <= '0;
    end else if (!en_i) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      empty_q <= ~full_q;  // flag trails the register by one cycle
      if (wr_i && !direct_i) begin
        full_q <= 1'b1;
        data_q <= data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o  = full_q;
  assign data_o  = data_q;
  assign empty_o = empty_q;

  p_flag_lag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> empty_q);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          mode9_i,
  input  logic          bit9_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  output logic          can_take_o,
  output logic          busy_o,
  output logic          serial_o,
  output logic          empty_o
);
  localparam int unsigned IDX_W = $clog2(DW + 1);

  tx_state_e        state_q;
  logic [DW:0]      sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             nb9_q, staged_q, last;

  assign last = (idx_q == (nb9_q ? IDX_W'(DW) : IDX_W'(DW - 1)));

  assign can_take_o = en_i && ((state_q == ST_IDLE) ||
                               (state_q == ST_STOP && !staged_q) ||
                               (state_q == ST_DATA && tick_i && last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sh_q     <= '0;
      idx_q    <= '0;
      nb9_q    <= 1'b0;
      staged_q <= 1'b0;
    end else if (!en_i) begin
      state_q  <= ST_IDLE;
      staged_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (load_i) begin
          state_q <= ST_START;
          idx_q   <= '0;
        end
        ST_START: if (tick_i) begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA:  if (tick_i) begin
          sh_q <= {1'b0, sh_q[DW:1]};
          if (last) state_q <= ST_STOP;
          else      idx_q   <= idx_q + 1'b1;
        end
        ST_STOP:  if (tick_i) begin
          state_q  <= (staged_q || load_i) ? ST_START : ST_IDLE;
          staged_q <= 1'b0;
          idx_q    <= '0;
        end
        default:  state_q <= ST_IDLE;
      endcase
      if (load_i) begin
        sh_q  <= {bit9_i & mode9_i, load_data_i};
        nb9_q <= mode9_i;
        if (state_q != ST_IDLE && !(state_q == ST_STOP && tick_i))
          staged_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: serial_o = 1'b0;
      ST_DATA:  serial_o = sh_q[0];
      default:  serial_o = 1'b1;
    endcase
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign empty_o = (state_q == ST_IDLE) || (state_q == ST_STOP && !staged_q);

  p_no_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_STOP && staged_q && tick_i) |=> (state_q == ST_START));
  p_bit_index_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (idx_q <= IDX_W'(DW)));
  p_load_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> can_take_o);
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned HS_SH = 4,
  parameter int unsigned LS_SH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             bit9_i,
  input  logic             mode9_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hs_i,
  output logic             serial_o,
  output logic             hold_empty_o,
  output logic             shift_empty_o
);
  logic          can_take, busy, tick, hold_full, direct, take_hold, load;
  logic [DW-1:0] hold_data, load_data;

  assign direct    = wr_i && tx_en_i && can_take && !hold_full;
  assign take_hold = can_take && hold_full;
  assign load      = direct || take_hold;
  assign load_data = hold_full ? hold_data : wr_data_i;

  sertx_baud #(.DIV_W(DIV_W), .HS_SH(HS_SH), .LS_SH(LS_SH)) i_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && tx_en_i),
    .div_i  (div_i),
    .hs_i   (hs_i),
    .tick_o (tick)
  );

  sertx_hold #(.DW(DW)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tx_en_i),
    .wr_i     (wr_i && tx_en_i),
    .direct_i (direct),
    .take_i   (take_hold),
    .data_i   (wr_data_i),
    .full_o   (hold_full),
    .data_o   (hold_data),
    .empty_o  (hold_empty_o)
  );

  sertx_shift #(.DW(DW)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tx_en_i),
    .tick_i      (tick),
    .mode9_i     (mode9_i),
    .bit9_i      (bit9_i),
    .load_i      (load),
    .load_data_i (load_data),
    .can_take_o  (can_take),
    .busy_o      (busy),
    .serial_o    (serial_o),
    .empty_o     (shift_empty_o)
  );

  p_direct_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tx_en_i && shift_empty_o && !hold_full && hold_empty_o)
    |=> (hold_empty_o && !shift_empty_o && !serial_o));
  p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (serial_o && hold_empty_o && shift_empty_o));
  p_stop_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> serial_o);
endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b1;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       bit9_i = 1'b0;
  logic       mode9_i = 1'b0;
  logic [7:0] div_i = '0;
  logic       hs_i = 1'b1;
  logic       serial_o, hold_empty_o, shift_empty_o;

  int nvec = 0;
  int nerr = 0;
  int cyc = 0;
  logic [8:0] exp_q[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  sertx_top i_sertx_top (.*);

  function automatic int bit_period(input int n, input logic hs);
    return (n + 1) * (hs ? 16 : 64);
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic at(input int n);
    while (cyc < n) @(negedge clk_i);
  endtask

  // drive at a negedge; the word is sampled at edge cyc+1
  task automatic put(input logic [7:0] d, input logic b9);
    wr_i = 1'b1; wr_data_i = d; bit9_i = b9;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic wait_idle(input int p);
    while (!(shift_empty_o && hold_empty_o)) @(negedge clk_i);
    repeat (p + 4) @(negedge clk_i);
  endtask

  task automatic rx_frame(input int p, input int nb, output logic [8:0] w, output logic st_ok);
    w = '0;
    while (serial_o !== 1'b0) @(negedge clk_i);
    repeat (p / 2) @(negedge clk_i);
    for (int i = 0; i < nb; i++) begin
      repeat (p) @(negedge clk_i);
      w[i] = serial_o;
    end
    repeat (p) @(negedge clk_i);
    st_ok = serial_o;
  endtask

  task automatic rand_phase(input int n, input logic hs, input logic m9, input int words);
    int p;
    p = bit_period(n, hs);
    div_i = 8'(n); hs_i = hs; mode9_i = m9;
    repeat (3) @(negedge clk_i);
    fork
      begin
        for (int w = 0; w < words; w++) begin
          logic [7:0] d;
          logic b9;
          repeat ($urandom_range(0, 40)) @(negedge clk_i);
          while (!hold_empty_o) @(negedge clk_i);
          d = 8'($urandom);
          b9 = 1'($urandom);
          exp_q.push_back({b9 & m9, d});
          put(d, b9);
          @(negedge clk_i);
        end
      end
      begin
        for (int w = 0; w < words; w++) begin
          logic [8:0] got, ex;
          logic st;
          rx_frame(p, m9 ? 9 : 8, got, st);
          ex = exp_q.pop_front();
          chk("R2 R7 frame data", got, ex);
          chk("R9 stop bit high", {8'h0, st}, 9'h1);
        end
      end
    join
    wait_idle(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int k, s;
    void'($urandom(32'h5eed_0077));
    repeat (3) @(negedge clk_i);
    chk("R1 reset line", {8'h0, serial_o}, 9'h1);
    chk("R1 reset hold flag", {8'h0, hold_empty_o}, 9'h1);
    chk("R1 reset shift flag", {8'h0, shift_empty_o}, 9'h1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 idle after reset", {6'h0, serial_o, hold_empty_o, shift_empty_o}, 9'h7);

    // direct pass, queued word, transfer and flag timing, P=16
    k = cyc + 1; put(8'hA5, 1'b0);
    chk("R3 start bit on line", {8'h0, serial_o}, 9'h0);
    chk("R3 hold flag stays set", {8'h0, hold_empty_o}, 9'h1);
    chk("R3 shift flag clear", {8'h0, shift_empty_o}, 9'h0);
    at(k + 1); put(8'h3C, 1'b0);
    chk("R4 hold flag still set", {8'h0, hold_empty_o}, 9'h1);
    at(k + 3); chk("R4 hold flag clear", {8'h0, hold_empty_o}, 9'h0);
    at(k + 24); chk("R2 bit0 of A5", {8'h0, serial_o}, 9'h1);
    at(k + 40); chk("R2 bit1 of A5", {8'h0, serial_o}, 9'h0);
    at(k + 144); chk("R5 hold still full", {8'h0, hold_empty_o}, 9'h0);
    at(k + 145); chk("R5 hold flag after transfer", {8'h0, hold_empty_o}, 9'h1);
    at(k + 150); chk("R6 staged stop keeps flag low", {8'h0, shift_empty_o}, 9'h0);
    chk("R2 stop high", {8'h0, serial_o}, 9'h1);
    at(k + 159); chk("R5 stop before next", {8'h0, serial_o}, 9'h1);
    at(k + 160); chk("R5 no gap start", {8'h0, serial_o}, 9'h0);
    at(k + 184); chk("R2 bit0 of 3C", {8'h0, serial_o}, 9'h0);
    at(k + 216); chk("R2 bit2 of 3C", {8'h0, serial_o}, 9'h1);
    at(k + 303); chk("R6 before last stop", {8'h0, shift_empty_o}, 9'h0);
    at(k + 304); chk("R6 rises at stop start", {8'h0, shift_empty_o}, 9'h1);
    chk("R6 line high in stop", {8'h0, serial_o}, 9'h1);
    at(k + 330); chk("R1 idle again", {6'h0, serial_o, hold_empty_o, shift_empty_o}, 9'h7);

    // ninth bit sampled at transfer, two stop bits
    mode9_i = 1'b1; repeat (2) @(negedge clk_i);
    k = cyc + 1; put(8'h00, 1'b1);
    at(k + 1); put(8'h00, 1'b0);
    at(k + 5); bit9_i = 1'b1;
    at(k + 136); chk("R2 9-bit bit7", {8'h0, serial_o}, 9'h0);
    at(k + 152); chk("R9 ninth bit high", {8'h0, serial_o}, 9'h1);
    at(k + 168); chk("R9 stop high", {8'h0, serial_o}, 9'h1);
    s = k + 176;
    at(s); chk("R5 9-bit next start", {8'h0, serial_o}, 9'h0);
    at(s + 136); chk("R8 held word bit7", {8'h0, serial_o}, 9'h0);
    at(s + 152); chk("R8 ninth bit from transfer", {8'h0, serial_o}, 9'h1);
    wait_idle(16);
    mode9_i = 1'b0; bit9_i = 1'b0;

    // overwrite of held word
    k = cyc + 1; put(8'h81, 1'b0);
    at(k + 1); put(8'h00, 1'b0);
    at(k + 3); put(8'hFF, 1'b0);
    s = k + 160;
    at(s + 24); chk("R10 new word bit0", {8'h0, serial_o}, 9'h1);
    at(s + 72); chk("R10 new word bit3", {8'h0, serial_o}, 9'h1);
    at(s + 170); chk("R10 no third frame flag", {8'h0, shift_empty_o}, 9'h1);
    at(s + 250); chk("R10 no third frame line", {8'h0, serial_o}, 9'h1);

    // abort
    k = cyc + 1; put(8'h00, 1'b0);
    at(k + 1); put(8'h55, 1'b0);
    at(k + 20); tx_en_i = 1'b0;
    at(k + 21); chk("R11 abort clears", {6'h0, serial_o, hold_empty_o, shift_empty_o}, 9'h7);
    at(k + 22); put(8'h00, 1'b0);
    chk("R11 write ignored", {6'h0, serial_o, hold_empty_o, shift_empty_o}, 9'h7);
    at(k + 30); tx_en_i = 1'b1;
    at(k + 50); chk("R11 held word dropped", {6'h0, serial_o, hold_empty_o, shift_empty_o}, 9'h7);
    at(k + 120); chk("R11 line stays idle", {8'h0, serial_o}, 9'h1);

    // timer restart on divisor and speed change
    div_i = 8'd3; repeat (3) @(negedge clk_i);
    k = cyc + 1; put(8'h01, 1'b0);
    at(k + 10); div_i = 8'd0;
    at(k + 26); chk("R12 start held to new period", {8'h0, serial_o}, 9'h0);
    at(k + 27); chk("R12 bit0 after new period", {8'h0, serial_o}, 9'h1);
    at(k + 30); hs_i = 1'b0;
    at(k + 94); chk("R12 bit0 held to slow period", {8'h0, serial_o}, 9'h1);
    at(k + 95); chk("R12 bit1 after speed change", {8'h0, serial_o}, 9'h0);
    wait_idle(64);

    // low speed exact period, N=0 -> 64 cycles
    div_i = 8'd0; hs_i = 1'b0; repeat (3) @(negedge clk_i);
    k = cyc + 1; put(8'h01, 1'b0);
    at(k + 63); chk("R7 start lasts 64", {8'h0, serial_o}, 9'h0);
    at(k + 64); chk("R7 bit0 at 64", {8'h0, serial_o}, 9'h1);
    at(k + 127); chk("R7 bit0 lasts 64", {8'h0, serial_o}, 9'h1);
    at(k + 128); chk("R7 bit1 at 128", {8'h0, serial_o}, 9'h0);
    wait_idle(64);

    rand_phase(0, 1'b1, 1'b0, 12);
    rand_phase(2, 1'b1, 1'b1, 10);
    rand_phase(0, 1'b0, 1'b0, 6);
    rand_phase(1, 1'b0, 1'b1, 4);
    chk("R1 idle at end", {6'h0, serial_o, hold_empty_o, shift_empty_o}, 9'h7);

    report();
    $finish;
  end
endmodule